// File: doc/BRIEF.md
# Two-Wire Digital Potentiometer Command Slave

This block is a two-wire serial slave that sits in front of a four-channel digital potentiometer controller. It samples the serial clock and data lines on the system clock and detects start and stop conditions. It checks an address byte against a fixed device type and a 4-bit strap address. It then takes an instruction byte and either moves one 6-bit value in or out, or acts at once. It holds the four volatile wiper counters and a sixteen-entry data register file, and it drives the data line only through an output enable that pulls the line low.

The instruction byte holds three fields. The opcode is in bits [7:4]. A register index in bits [3:2] picks one of the four data registers of a channel. A channel index in bits [1:0] picks the potentiometer. Data bytes carry two leading zero bits and then a 6-bit value, most significant bit first. A data register write starts a modeled nonvolatile write interval. While that interval runs, the slave does not answer its address. An increment/decrement command turns each later SCL high period into one saturating step of the selected wiper, until the master sends a stop.

Top module: `pot_cmd_slave`

## Requirements
- R1: After reset every wiper output equals `DR_INIT`, which is also the reset content of every data register, including register 0 of each channel. `nv_busy_o` and `sda_oe_o` are low.
- R2: The slave acknowledges the first byte after a start only when its upper nibble is 0101 and its lower nibble equals `strap_addr_i`. Otherwise it gives no acknowledge and the rest of the frame has no effect.
- R3: The instruction byte is opcode[7:4], register index [3:2] and channel [1:0]. Opcodes outside {0010, 1001, 1010, 1011, 1100, 1101} get no acknowledge and the frame has no effect.
- R4: Opcode 1010 takes a data byte 00 followed by six value bits. The slave acknowledges it and the selected wiper output takes the value.
- R5: Opcode 1001 makes the slave send 00 followed by the selected wiper value, MSB first, and then release the line for the master's acknowledge. The output enable changes only after an SCL falling edge, a start or a stop.
- R6: Opcode 1100 stores the data byte's value in data register (channel, index). `nv_busy_o` then stays high for exactly `NV_CYCLES` clock cycles.
- R7: Opcode 1011 sends 00 followed by data register (channel, index), MSB first.
- R8: Opcode 1101 copies data register (channel, index) into that channel's wiper. The frame has no data byte.
- R9: After opcode 0010 is acknowledged, each SCL high period with SDA high adds one to the channel's wiper, and each with SDA low subtracts one. The wiper saturates at 0 and 63, and the closing stop adds no step.
- R10: While `nv_busy_o` is high, the address byte gets no acknowledge even when it matches.
- R11: A stop or a new start in the middle of a frame aborts it. A data byte cut off this way changes nothing, and a frame after a repeated start works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the wire |
| strap_addr_i | input | 4 | Strapped device address |
| sda_oe_o | output | 1 | Pull the data line low when high |
| nv_busy_o | output | 1 | Nonvolatile write interval in progress |
| wiper_o | output | 24 | Wiper positions, channel c at bits [6c+5:6c] |

## Verification
The hardest cases to reach are the saturating ends of increment/decrement mode and the closing stop. The stop's final SCL rise comes with SDA low, so it looks like the start of one more decrement pulse. The bench first writes wipers to 62 and 1, then sends long one-direction pulse trains against those limits. Writes also go in the middle of frames cut off by stops and repeated starts, and a matching address is sent while a register write is still busy. Random mixes of all opcodes with random channels, indices and pulse patterns then run against a bench model of the wipers and the register file.

// File: rtl/pot_pkg.sv
package pot_pkg;
  localparam int unsigned WIPER_W = 6;
  localparam int unsigned N_CH    = 4;
  localparam int unsigned N_DR    = 4;
  localparam int unsigned CH_W    = $clog2(N_CH);
  localparam int unsigned RG_W    = $clog2(N_DR);
  localparam int unsigned DA_W    = CH_W + RG_W;

  localparam logic [3:0] DEV_TYPE  = 4'b0101;
  localparam logic [3:0] OP_STEP   = 4'b0010;
  localparam logic [3:0] OP_RD_WCR = 4'b1001;
  localparam logic [3:0] OP_WR_WCR = 4'b1010;
  localparam logic [3:0] OP_RD_DR  = 4'b1011;
  localparam logic [3:0] OP_WR_DR  = 4'b1100;
  localparam logic [3:0] OP_XFR    = 4'b1101;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ACK_A, ST_INSTR, ST_ACK_I,
    ST_WDATA, ST_ACK_D, ST_RDATA, ST_MACK, ST_STEP, ST_SKIP
  } state_e;

  function automatic logic op_known(logic [3:0] op);
    return op inside {OP_STEP, OP_RD_WCR, OP_WR_WCR, OP_RD_DR, OP_WR_DR, OP_XFR};
  endfunction
endpackage

// File: rtl/pot_line_sync.sv
module pot_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p, scl_s;

  assign scl_s = scl_sh[STAGES-1];
  assign sda_o = sda_sh[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_p  <= scl_s;
      sda_p  <= sda_o;
    end
  end

  assign scl_rise_o = scl_s & ~scl_p;
  assign scl_fall_o = ~scl_s & scl_p;
  assign start_o    = scl_s & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_s & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/pot_wiper_bank.sv
module pot_wiper_bank
  import pot_pkg::*;
#(
  parameter logic [WIPER_W-1:0] DR_INIT = 6'h20
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [CH_W-1:0]           ch_i,
  input  logic [WIPER_W-1:0]        wr_val_i,
  input  logic                      step_en_i,
  input  logic                      step_up_i,
  output logic [N_CH*WIPER_W-1:0]   wiper_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [WIPER_W-1:0] w_q;
    logic sel;
    assign sel = (ch_i == CH_W'(c));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   w_q <= DR_INIT;  // value of register 0 at power-up
      else if (wr_en_i && sel)       w_q <= wr_val_i;
      else if (step_en_i && sel) begin
        if (step_up_i && w_q != '1)       w_q <= w_q + 1'b1;
        else if (!step_up_i && w_q != '0) w_q <= w_q - 1'b1;
      end
    end
    assign wiper_o[c*WIPER_W +: WIPER_W] = w_q;
  end
endmodule

// File: rtl/pot_dreg_file.sv
module pot_dreg_file
  import pot_pkg::*;
#(
  parameter int unsigned        NV_CYCLES = 500000,
  parameter logic [WIPER_W-1:0] DR_INIT   = 6'h20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [DA_W-1:0]    addr_i,
  input  logic [WIPER_W-1:0] wdata_i,
  output logic [WIPER_W-1:0] rdata_o,
  output logic               busy_o
);
  localparam int unsigned DEPTH = N_CH * N_DR;
  localparam int unsigned CW    = $clog2(NV_CYCLES + 1);

  logic [WIPER_W-1:0] mem_q [DEPTH];
  logic [CW-1:0]      tmr_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           mem_q[i] <= DR_INIT;
      else if (we_i && addr_i == DA_W'(i))   mem_q[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           tmr_q <= '0;
    else if (we_i)         tmr_q <= CW'(NV_CYCLES);
    else if (tmr_q != '0)  tmr_q <= tmr_q - 1'b1;
  end

  assign rdata_o = mem_q[addr_i];
  assign busy_o  = (tmr_q != '0);
endmodule

// File: rtl/pot_cmd_slave.sv
module pot_cmd_slave
  import pot_pkg::*;
#(
  parameter int unsigned        NV_CYCLES   = 500000,
  parameter logic [WIPER_W-1:0] DR_INIT     = 6'h20,
  parameter int unsigned        SYNC_STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    scl_i,
  input  logic                    sda_i,
  input  logic [3:0]              strap_addr_i,
  output logic                    sda_oe_o,
  output logic                    nv_busy_o,
  output logic [N_CH*WIPER_W-1:0] wiper_o
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  state_e state_q;
  logic [3:0] cnt_q, op_q;
  logic [7:0] sh_q, tx_q;
  logic [RG_W-1:0] reg_q;
  logic [CH_W-1:0] ch_q;
  logic pend_q, dir_q;
  logic wwr_q, dwe_q, stp_q, stp_up_q;
  logic [WIPER_W-1:0] wval_q, dval_q, dr_rdata, cur_wiper;

  pot_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  pot_wiper_bank #(.DR_INIT(DR_INIT)) i_wipers (
    .clk_i, .rst_ni, .wr_en_i(wwr_q), .ch_i(ch_q), .wr_val_i(wval_q),
    .step_en_i(stp_q), .step_up_i(stp_up_q), .wiper_o
  );

  pot_dreg_file #(.NV_CYCLES(NV_CYCLES), .DR_INIT(DR_INIT)) i_dregs (
    .clk_i, .rst_ni, .we_i(dwe_q), .addr_i({ch_q, reg_q}), .wdata_i(dval_q),
    .rdata_o(dr_rdata), .busy_o(nv_busy_o)
  );

  assign cur_wiper = wiper_o[ch_q*WIPER_W +: WIPER_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;  cnt_q <= '0;  sh_q <= '0;  tx_q <= '0;
      op_q <= '0;  reg_q <= '0;  ch_q <= '0;  sda_oe_o <= 1'b0;
      pend_q <= 1'b0;  dir_q <= 1'b0;
      wwr_q <= 1'b0;  dwe_q <= 1'b0;  stp_q <= 1'b0;  stp_up_q <= 1'b0;
      wval_q <= '0;  dval_q <= '0;
    end else begin
      wwr_q <= 1'b0;
      dwe_q <= 1'b0;
      stp_q <= 1'b0;
      if (stop_det) begin
        state_q <= ST_IDLE;  sda_oe_o <= 1'b0;  pend_q <= 1'b0;
      end else if (start_det) begin
        state_q <= ST_ADDR;  cnt_q <= '0;  sda_oe_o <= 1'b0;  pend_q <= 1'b0;
      end else begin
        if (scl_rise) begin
          sh_q  <= {sh_q[6:0], sda_s};
          cnt_q <= cnt_q + 1'b1;
          if (state_q == ST_STEP) begin
            pend_q <= 1'b1;
            dir_q  <= sda_s;
          end
        end
        if (scl_fall) begin
          unique case (state_q)
            ST_ADDR: if (cnt_q == 4'd8) begin
              if (sh_q[7:4] == DEV_TYPE && sh_q[3:0] == strap_addr_i && !nv_busy_o) begin
                state_q <= ST_ACK_A;  sda_oe_o <= 1'b1;
              end else state_q <= ST_SKIP;
            end
            ST_ACK_A: begin
              state_q <= ST_INSTR;  cnt_q <= '0;  sda_oe_o <= 1'b0;
            end
            ST_INSTR: if (cnt_q == 4'd8) begin
              op_q  <= sh_q[7:4];
              reg_q <= sh_q[3:2];
              ch_q  <= sh_q[1:0];
              if (op_known(sh_q[7:4])) begin
                state_q <= ST_ACK_I;  sda_oe_o <= 1'b1;
              end else state_q <= ST_SKIP;
            end
            ST_ACK_I: begin
              cnt_q    <= '0;
              sda_oe_o <= 1'b0;
              unique case (op_q)
                OP_RD_WCR, OP_RD_DR: begin
                  tx_q     <= {2'b00, (op_q == OP_RD_WCR) ? cur_wiper : dr_rdata};
                  sda_oe_o <= 1'b1;  // leading bit is always 0
                  state_q  <= ST_RDATA;
                end
                OP_WR_WCR, OP_WR_DR: state_q <= ST_WDATA;
                OP_XFR: begin
                  wwr_q   <= 1'b1;  wval_q <= dr_rdata;  state_q <= ST_SKIP;
                end
                default: begin
                  pend_q <= 1'b0;  state_q <= ST_STEP;
                end
              endcase
            end
            ST_WDATA: if (cnt_q == 4'd8) begin
              sda_oe_o <= 1'b1;
              state_q  <= ST_ACK_D;
              if (op_q == OP_WR_WCR) begin
                wwr_q <= 1'b1;  wval_q <= sh_q[5:0];
              end else begin
                dwe_q <= 1'b1;  dval_q <= sh_q[5:0];
              end
            end
            ST_ACK_D: begin
              sda_oe_o <= 1'b0;  state_q <= ST_SKIP;
            end
            ST_RDATA: begin
              if (cnt_q == 4'd8) begin
                sda_oe_o <= 1'b0;  state_q <= ST_MACK;
              end else begin
                sda_oe_o <= ~tx_q[6];
                tx_q     <= {tx_q[6:0], 1'b0};
              end
            end
            ST_MACK: state_q <= ST_SKIP;
            ST_STEP: if (pend_q) begin
              stp_q <= 1'b1;  stp_up_q <= dir_q;  pend_q <= 1'b0;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/pot_cmd_checker.sv
module pot_cmd_checker
  import pot_pkg::*;
(
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    sda_oe_o,
  input logic                    nv_busy_o,
  input logic [N_CH*WIPER_W-1:0] wiper_o,
  input logic                    scl_fall,
  input logic                    start_det,
  input logic                    stop_det,
  input state_e                  state_q,
  input logic                    dwe_q,
  input logic                    stp_q,
  input logic                    stp_up_q,
  input logic [CH_W-1:0]         ch_q
);
  logic [WIPER_W-1:0] sel_w;
  assign sel_w = wiper_o[ch_q*WIPER_W +: WIPER_W];

  AST_BUSY_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nv_busy_o) |-> $past(dwe_q)); // R6
  AST_NO_ACK_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ADDR && scl_fall && nv_busy_o) |=> state_q != ST_ACK_A); // R10
  AST_OE_MOVES_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(scl_fall || start_det || stop_det) |=> $stable(sda_oe_o)); // R5
  AST_STOP_GOES_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (state_q == ST_IDLE && !sda_oe_o)); // R11
  AST_STEP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stp_q && stp_up_q && sel_w != '1) |=> sel_w == WIPER_W'($past(sel_w) + 1'b1)); // R9
  AST_STEP_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stp_q && !stp_up_q && sel_w == '0) |=> sel_w == '0); // R9
endmodule

bind pot_cmd_slave pot_cmd_checker i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sda_oe_o(sda_oe_o), .nv_busy_o(nv_busy_o),
  .wiper_o(wiper_o), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
  .state_q(state_q), .dwe_q(dwe_q), .stp_q(stp_q), .stp_up_q(stp_up_q), .ch_q(ch_q)
);

// File: tb/test_pot_cmd_slave.sv
module test_pot_cmd_slave;
  localparam int unsigned NV   = 400;
  localparam logic [5:0]  INIT = 6'h20;
  localparam logic [3:0]  STRAP = 4'hA;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, busy;
  logic [23:0] wiper;
  wire sda_line = sda_m & ~sda_oe;

  always #10 clk = ~clk;  // 50 MHz

  pot_cmd_slave #(.NV_CYCLES(NV), .DR_INIT(INIT), .SYNC_STAGES(2)) i_pot_cmd_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .strap_addr_i(STRAP), .sda_oe_o(sda_oe), .nv_busy_o(busy), .wiper_o(wiper)
  );

  int total = 0, bad = 0, busy_cnt = 0;
  bit done = 0;
  logic [5:0] mw [4];
  logic [5:0] md [16];

  always @(negedge clk) if (busy) busy_cnt++;

  function automatic logic [5:0] step_val(logic [5:0] v, bit up);
    if (up) return (v == 6'h3f) ? v : v + 6'd1;
    return (v == 6'h00) ? v : v - 6'd1;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_c();
    sda_m = 1'b1; tick(3); scl_m = 1'b1; tick(5); sda_m = 1'b0; tick(5); scl_m = 1'b0; tick(5);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; tick(5); scl_m = 1'b1; tick(5); sda_m = 1'b1; tick(5);
  endtask

  task automatic bit_c(input logic b, output logic r);
    sda_m = b; tick(5); scl_m = 1'b1; tick(5); r = sda_line; tick(5); scl_m = 1'b0; tick(5);
  endtask

  task automatic byte_c(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_c(b[i], r);
    bit_c(1'b1, r);
    ack = ~r;
  endtask

  task automatic rbyte_c(output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_c(1'b1, r);
      v[i] = r;
    end
    bit_c(1'b1, r);  // master no-ack
  endtask

  task automatic wr_frame(input logic [3:0] op, input logic [1:0] ch, input logic [1:0] rg,
                          input logic [5:0] val, output logic ok);
    logic a1, a2, a3;
    start_c();
    byte_c({4'b0101, STRAP}, a1);
    byte_c({op, rg, ch}, a2);
    byte_c({2'b00, val}, a3);
    stop_c();
    ok = a1 & a2 & a3;
  endtask

  task automatic rd_frame(input logic [3:0] op, input logic [1:0] ch, input logic [1:0] rg,
                          output logic [7:0] v, output logic ok);
    logic a1, a2;
    start_c();
    byte_c({4'b0101, STRAP}, a1);
    byte_c({op, rg, ch}, a2);
    rbyte_c(v);
    stop_c();
    ok = a1 & a2;
  endtask

  task automatic xfr_frame(input logic [1:0] ch, input logic [1:0] rg, output logic ok);
    logic a1, a2;
    start_c();
    byte_c({4'b0101, STRAP}, a1);
    byte_c({4'b1101, rg, ch}, a2);
    stop_c();
    ok = a1 & a2;
  endtask

  task automatic step_frame(input logic [1:0] ch, input logic [31:0] dirs, input int n,
                            output logic ok);
    logic a1, a2, r;
    start_c();
    byte_c({4'b0101, STRAP}, a1);
    byte_c({4'b0010, 2'b00, ch}, a2);
    for (int i = 0; i < n; i++) bit_c(dirs[i], r);
    stop_c();
    ok = a1 & a2;
  endtask

  task automatic wait_idle();
    while (busy) tick(1);
    tick(2);
  endtask

  task automatic chk_wipers(string req);
    for (int c = 0; c < 4; c++)
      chk(wiper[c*6 +: 6] == mw[c], req, wiper[c*6 +: 6], mw[c]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic ok, a;
    logic [7:0] v;
    void'($urandom(32'd11));
    for (int c = 0; c < 4; c++) mw[c] = INIT;
    for (int i = 0; i < 16; i++) md[i] = INIT;
    tick(5);
    // R1: reset state
    chk(wiper == {4{INIT}}, "R1 wipers", wiper, {4{INIT}});
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
    rst_n = 1'b1;
    tick(5);
    rd_frame(4'b1011, 2'd1, 2'd0, v, ok);
    chk(ok && v == {2'b00, INIT}, "R1 dr0 content", v, {2'b00, INIT});

    // R4/R5: wiper write and read back
    wr_frame(4'b1010, 2'd1, 2'd0, 6'h15, ok); mw[1] = 6'h15;
    chk(ok, "R4 acks", ok, 1);
    chk_wipers("R4 wiper_o");
    rd_frame(4'b1001, 2'd1, 2'd0, v, ok);
    chk(ok && v == 8'h15, "R5 read wiper", v, 8'h15);
    rd_frame(4'b1001, 2'd3, 2'd0, v, ok);
    chk(ok && v == {2'b00, INIT}, "R5 read wiper ch3", v, {2'b00, INIT});

    // R6/R10/R7: data register write, busy window, read back
    busy_cnt = 0;
    wr_frame(4'b1100, 2'd2, 2'd3, 6'h2a, ok); md[{2'd2, 2'd3}] = 6'h2a;
    chk(ok, "R6 acks", ok, 1);
    chk(busy == 1'b1, "R6 busy high", busy, 1);
    start_c(); byte_c({4'b0101, STRAP}, a); stop_c();
    chk(!a, "R10 nack while busy", a, 0);
    wait_idle();
    chk(busy_cnt == NV, "R6 busy length", busy_cnt, NV);
    rd_frame(4'b1011, 2'd2, 2'd3, v, ok);
    chk(ok && v == 8'h2a, "R7 read dr", v, 8'h2a);

    // R8: transfer
    xfr_frame(2'd2, 2'd3, ok); mw[2] = 6'h2a;
    chk(ok, "R8 acks", ok, 1);
    tick(3);
    chk_wipers("R8 wiper_o");

    // R2: wrong address and wrong device type
    start_c(); byte_c({4'b0101, 4'h5}, a);
    byte_c({4'b1010, 2'b00, 2'd0}, ok); byte_c(8'h01, ok); stop_c();
    chk(!a, "R2 strap mismatch nack", a, 0);
    start_c(); byte_c({4'b0110, STRAP}, a);
    byte_c({4'b1010, 2'b00, 2'd0}, ok); byte_c(8'h02, ok); stop_c();
    chk(!a, "R2 type mismatch nack", a, 0);
    chk_wipers("R2 ignored frame");

    // R3: unknown opcode
    start_c(); byte_c({4'b0101, STRAP}, a); byte_c({4'b0111, 2'b00, 2'd0}, ok);
    byte_c(8'h03, a); stop_c();
    chk(!ok, "R3 unknown opcode nack", ok, 0);
    chk_wipers("R3 ignored frame");

    // R9: saturation at both ends
    wr_frame(4'b1010, 2'd0, 2'd0, 6'h3e, ok); mw[0] = 6'h3e;
    step_frame(2'd0, 32'h7, 3, ok); mw[0] = 6'h3f;
    chk(ok, "R9 step acks", ok, 1);
    chk_wipers("R9 top saturation");
    wr_frame(4'b1010, 2'd3, 2'd0, 6'h01, ok); mw[3] = 6'h01;
    step_frame(2'd3, 32'h0, 4, ok); mw[3] = 6'h00;
    chk_wipers("R9 floor saturation");
    step_frame(2'd3, 32'b1011, 4, ok); mw[3] = 6'h02;
    chk_wipers("R9 mixed steps");

    // R11: aborted write, then repeated start
    start_c(); byte_c({4'b0101, STRAP}, a); byte_c({4'b1010, 2'b00, 2'd1}, a);
    for (int i = 0; i < 4; i++) bit_c(1'b1, ok);
    stop_c();
    chk_wipers("R11 stop abort");
    start_c(); byte_c({4'b0101, STRAP}, a); byte_c({4'b1100, 2'd1, 2'd1}, a);
    for (int i = 0; i < 5; i++) bit_c(1'b0, ok);
    start_c(); byte_c({4'b0101, STRAP}, a); byte_c({4'b1010, 2'b00, 2'd1}, ok);
    byte_c(8'h09, a); stop_c(); mw[1] = 6'h09;
    chk(ok && a && !busy, "R11 repeated start frame", {ok, a, busy}, 3'b110);
    chk_wipers("R11 repeated start");

    // random mix
    for (int n = 0; n < 50; n++) begin
      int op = $urandom_range(0, 5);
      logic [1:0] ch = 2'($urandom_range(0, 3));
      logic [1:0] rg = 2'($urandom_range(0, 3));
      logic [5:0] val = 6'($urandom);
      case (op)
        0: begin wr_frame(4'b1010, ch, 2'b00, val, ok); mw[ch] = val;
                 chk(ok, "R4 random ack", ok, 1); end
        1: begin rd_frame(4'b1001, ch, 2'b00, v, ok);
                 chk(ok && v == {2'b00, mw[ch]}, "R5 random read", v, {2'b00, mw[ch]}); end
        2: begin wr_frame(4'b1100, ch, rg, val, ok); md[{ch, rg}] = val;
                 chk(ok, "R6 random ack", ok, 1); wait_idle(); end
        3: begin rd_frame(4'b1011, ch, rg, v, ok);
                 chk(ok && v == {2'b00, md[{ch, rg}]}, "R7 random read", v, {2'b00, md[{ch, rg}]}); end
        4: begin xfr_frame(ch, rg, ok); mw[ch] = md[{ch, rg}];
                 chk(ok, "R8 random ack", ok, 1); end
        default: begin
          logic [31:0] d = $urandom;
          int k = $urandom_range(1, 12);
          step_frame(ch, d, k, ok);
          for (int i = 0; i < k; i++) mw[ch] = step_val(mw[ch], d[i]);
        end
      endcase
      tick(3);
      chk_wipers("R9 random wipers");
    end
    finish_run();
  end
endmodule